// File: doc/BRIEF.md
# Stable Row-Group Selector

This block picks the single row group that will stand for one memory subarray during enrolment. A controller activates each candidate group many times and streams every readout into the block. A readout arrives as a run of fixed-width words. The block first filters each candidate on how balanced its first readout is. It then tracks, for every response bit, how often that bit read as one across the repeated trials. When the final trial ends, it converts each bit's count into a fixed-point Shannon entropy and adds these values up.

Every candidate has the same number of bits, so the candidate with the lowest summed entropy is also the one with the lowest average per-bit entropy. After the controller closes the subarray, the block reports the identifier of that candidate. If no candidate passed the balance filter, it reports an error flag instead. Only one group is kept per subarray, because groups that share a subarray are correlated.

The per-bit counters are held in a single memory addressed by word index and updated by read-modify-write at one word per cycle. The input is held off for one cycle when a word would read an address whose update has not yet been written back.

Top module: `row_group_selector`

## Requirements
- R1: After reset, `win_valid` and `win_none` are low and `resp_ready` is high.
- R2: A beat with `resp_cand_first` high starts a new candidate, starts its first trial, and latches `resp_gid`. A beat with `resp_trial_first` high starts a trial. Word k of a trial carries response bits [k*WORD_W +: WORD_W]. Every trial has RESP_BITS/WORD_W words.
- R3: A candidate is eligible only if its first trial holds at least MIN_ONES ones and at least MIN_ZEROS zeros. The data of later trials never changes eligibility.
- R4: Each bit's one count k over the TRIALS trials is mapped to round(2^ENT_FRAC * H(k/TRIALS)), where H is the binary Shannon entropy. H is zero for k = 0 and k = TRIALS. The candidate score is the sum of these values over all bits.
- R5: Among eligible candidates, the one with the lowest score is selected.
- R6: When two eligible candidates have equal scores, the one streamed earlier is kept.
- R7: If the input stream is idle, a one-cycle `sel_close` pulse makes the outputs change two clock edges later. At that point exactly one of `win_valid` (with `win_gid`) or `win_none` goes high. The result then holds until `sel_start`.
- R8: If no candidate since the last `sel_start` was eligible, the close raises `win_none` and leaves `win_valid` low.
- R9: `resp_ready` goes low for exactly one cycle when the incoming word index equals that of the word accepted in the previous cycle. Otherwise words are accepted on every cycle.
- R10: `sel_start` clears both result flags by the next cycle and forgets every earlier candidate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sel_start | input | 1 | Begin a new subarray; clears the stored best and the result |
| sel_close | input | 1 | End of candidates; request the decision |
| resp_valid | input | 1 | Response word present |
| resp_ready | output | 1 | Word accepted when high together with valid |
| resp_word | input | WORD_W | Response word |
| resp_cand_first | input | 1 | First word of a candidate's first trial |
| resp_trial_first | input | 1 | First word of a trial |
| resp_gid | input | GID_W | Group identifier, sampled with resp_cand_first |
| win_valid | output | 1 | Selected group is reported |
| win_gid | output | GID_W | Identifier of the selected group |
| win_none | output | 1 | No candidate passed the balance filter |

## Verification
Each scenario uses its own set of candidates.

- **Ranking.** A noisy candidate is followed by two candidates with equal non-zero scores. This separates a correct minimum search from one that keeps the last or the first arrival, and tests the tie rule.
- **Balance filter.** Some candidates have a first trial just inside and just outside the one and zero limits. Some of these stay perfectly stable afterwards, and others turn unbalanced only in later trials. A filter that uses the wrong trial or an off-by-one limit would then pick a different winner.
- **No winner and restart.** An all-ineligible set checks the error flag. A fresh subarray after it shows that old results are forgotten.
- **Hazard stall.** A one-word configuration streamed back to back exercises the stall, with an exact count of stalled cycles.

// File: rtl/row_group_selector.sv
module row_group_selector #(
  parameter int WORD_W    = 64,
  parameter int RESP_BITS = 65536,
  parameter int TRIALS    = 100,
  parameter int MIN_ONES  = 512,
  parameter int MIN_ZEROS = 512,
  parameter int ENT_FRAC  = 8,
  parameter int GID_W     = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sel_start,
  input  logic             sel_close,
  input  logic             resp_valid,
  output logic             resp_ready,
  input  logic [WORD_W-1:0] resp_word,
  input  logic             resp_cand_first,
  input  logic             resp_trial_first,
  input  logic [GID_W-1:0] resp_gid,
  output logic             win_valid,
  output logic [GID_W-1:0] win_gid,
  output logic             win_none
);
  localparam int WORDS = RESP_BITS / WORD_W;
  localparam int AW    = (WORDS > 1) ? $clog2(WORDS) : 1;
  localparam int CW    = $clog2(TRIALS + 1);
  localparam int TW    = (TRIALS > 1) ? $clog2(TRIALS) : 1;
  localparam int EW    = ENT_FRAC + 1;
  localparam int PW    = $clog2(RESP_BITS + 1);
  localparam int LW    = $clog2(WORD_W + 1);
  localparam int SW    = EW + PW;
  localparam int WSW   = EW + LW;

  function automatic int unsigned ent_of(int k);
    real p, h;
    if (k <= 0 || k >= TRIALS) return 0;
    p = real'(k) / real'(TRIALS);
    h = -(p * $ln(p) + (1.0 - p) * $ln(1.0 - p)) / $ln(2.0);
    return $rtoi(h * real'(1 << ENT_FRAC) + 0.5);
  endfunction

  logic [EW-1:0] ent_lut [TRIALS+1];
  for (genvar c = 0; c <= TRIALS; c++) begin : g_lut
    localparam int unsigned EV = ent_of(c);
    assign ent_lut[c] = EW'(EV);
  end

  // input stage
  logic [AW-1:0]        widx_q;
  logic [TW-1:0]        tidx_q;
  logic                 s1_v_q, s1_first_q, s1_last_q;
  logic [AW-1:0]        s1_addr_q;
  logic [WORD_W-1:0]    s1_data_q;
  logic [WORD_W*CW-1:0] rd_q, wr_flat;
  logic [WORD_W*CW-1:0] mem [WORDS];
  logic [GID_W-1:0]     cur_gid_q;

  wire           trial_start = resp_trial_first | resp_cand_first;
  wire [AW-1:0]  in_addr  = trial_start ? '0 : widx_q;
  wire [TW-1:0]  in_trial = resp_cand_first ? '0 :
                            (resp_trial_first ? tidx_q + 1'b1 : tidx_q);
  wire [AW-1:0]  nxt_addr = (in_addr == AW'(WORDS - 1)) ? '0 : in_addr + 1'b1;

  assign resp_ready = !(s1_v_q && s1_addr_q == in_addr);
  wire acc = resp_valid && resp_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      widx_q     <= '0;
      tidx_q     <= '0;
      s1_v_q     <= 1'b0;
      s1_first_q <= 1'b0;
      s1_last_q  <= 1'b0;
      s1_addr_q  <= '0;
      s1_data_q  <= '0;
      cur_gid_q  <= '0;
    end else begin
      s1_v_q <= acc;
      if (acc) begin
        widx_q     <= nxt_addr;
        tidx_q     <= in_trial;
        s1_addr_q  <= in_addr;
        s1_data_q  <= resp_word;
        s1_first_q <= (in_trial == '0);
        s1_last_q  <= (in_trial == TW'(TRIALS - 1));
        if (resp_cand_first) cur_gid_q <= resp_gid;
      end
    end
  end

  // counter memory, read one cycle ahead of its write-back
  always_ff @(posedge clk) begin
    if (acc) rd_q <= mem[in_addr];
    if (s1_v_q) mem[s1_addr_q] <= wr_flat;
  end

  // update stage
  logic [CW-1:0] lane_new [WORD_W];
  for (genvar i = 0; i < WORD_W; i++) begin : g_lane
    wire [CW-1:0] old = s1_first_q ? '0 : rd_q[i*CW +: CW];
    assign lane_new[i] = old + CW'(s1_data_q[i]);
    assign wr_flat[i*CW +: CW] = lane_new[i];
    // R4
    cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      s1_v_q |-> lane_new[i] <= CW'(TRIALS));
  end

  logic [LW-1:0]  pop;
  logic [WSW-1:0] wsum;
  always_comb begin
    pop  = '0;
    wsum = '0;
    for (int i = 0; i < WORD_W; i++) begin
      pop  = pop + LW'(s1_data_q[i]);
      wsum = wsum + WSW'(ent_lut[lane_new[i]]);
    end
  end

  logic [PW-1:0]    ones_q;
  logic [SW-1:0]    ent_q, best_q;
  logic             ok_q, have_q, pend_q;
  logic [GID_W-1:0] best_gid_q;

  wire          word0    = (s1_addr_q == '0);
  wire          last_wd  = (s1_addr_q == AW'(WORDS - 1));
  wire [PW-1:0] ones_tot = (word0 ? '0 : ones_q) + PW'(pop);
  wire          elig_now = (ones_tot >= PW'(MIN_ONES)) &&
                           (ones_tot <= PW'(RESP_BITS - MIN_ZEROS));
  wire          ok_eff   = s1_first_q ? elig_now : ok_q;
  wire [SW-1:0] ent_tot  = (word0 ? '0 : ent_q) + SW'(wsum);
  wire          fin      = s1_v_q && s1_last_q && last_wd;
  wire          upd      = fin && ok_eff && (!have_q || ent_tot < best_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ones_q     <= '0;
      ent_q      <= '0;
      ok_q       <= 1'b0;
      best_q     <= '0;
      best_gid_q <= '0;
      have_q     <= 1'b0;
      pend_q     <= 1'b0;
      win_valid  <= 1'b0;
      win_none   <= 1'b0;
      win_gid    <= '0;
    end else begin
      if (s1_v_q && s1_first_q) begin
        ones_q <= ones_tot;
        if (last_wd) ok_q <= elig_now;
      end
      if (s1_v_q && s1_last_q) ent_q <= ent_tot;
      if (sel_start) begin
        have_q    <= 1'b0;
        pend_q    <= 1'b0;
        win_valid <= 1'b0;
        win_none  <= 1'b0;
      end else begin
        if (upd) begin
          have_q     <= 1'b1;
          best_q     <= ent_tot;
          best_gid_q <= cur_gid_q;
        end
        if (sel_close) pend_q <= 1'b1;
        else if (pend_q && !s1_v_q) begin
          pend_q    <= 1'b0;
          win_valid <= have_q;
          win_none  <= !have_q;
          win_gid   <= best_gid_q;
        end
      end
    end
  end

  // R9
  stall_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !resp_ready |=> resp_ready);
  // R7
  result_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(win_valid && win_none));
  // R7
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (win_valid && !sel_start) |=> win_valid && $stable(win_gid));
  // R10
  start_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sel_start |=> !win_valid && !win_none);
  // R5
  best_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (upd && have_q && !sel_start) |=> best_q < $past(best_q));
endmodule

// File: tb/row_group_selector_tb_top.sv
module row_group_selector_tb_top;
  localparam int T = 5;
  logic clk = 1'b0, rst_n = 1'b0;
  always #2 clk = ~clk;

  int n_chk = 0, n_bad = 0;
  int stalls [2];
  bit m_have [2];
  int m_best [2];
  int m_gid  [2];

  logic       a_start = 0, a_close = 0, a_valid = 0, a_cf = 0, a_tf = 0;
  logic [7:0] a_word = 0;
  logic [3:0] a_gid = 0, a_wg;
  logic       a_ready, a_wv, a_wn;
  logic       b_start = 0, b_close = 0, b_valid = 0, b_cf = 0, b_tf = 0;
  logic [7:0] b_word = 0;
  logic [3:0] b_gid = 0, b_wg;
  logic       b_ready, b_wv, b_wn;

  row_group_selector #(.WORD_W(8), .RESP_BITS(16), .TRIALS(T), .MIN_ONES(3),
    .MIN_ZEROS(3), .ENT_FRAC(8), .GID_W(4)) dut_i (
    .clk(clk), .rst_n(rst_n), .sel_start(a_start), .sel_close(a_close),
    .resp_valid(a_valid), .resp_ready(a_ready), .resp_word(a_word),
    .resp_cand_first(a_cf), .resp_trial_first(a_tf), .resp_gid(a_gid),
    .win_valid(a_wv), .win_gid(a_wg), .win_none(a_wn));

  row_group_selector #(.WORD_W(8), .RESP_BITS(8), .TRIALS(T), .MIN_ONES(2),
    .MIN_ZEROS(2), .ENT_FRAC(8), .GID_W(4)) hz_i (
    .clk(clk), .rst_n(rst_n), .sel_start(b_start), .sel_close(b_close),
    .resp_valid(b_valid), .resp_ready(b_ready), .resp_word(b_word),
    .resp_cand_first(b_cf), .resp_trial_first(b_tf), .resp_gid(b_gid),
    .win_valid(b_wv), .win_gid(b_wg), .win_none(b_wn));

  function automatic int h_fix(int k);
    real p, h;
    if (k == 0 || k == T) return 0;
    p = real'(k) / real'(T);
    h = -(p * $ln(p) + (1.0 - p) * $ln(1.0 - p)) / $ln(2.0);
    return $rtoi(h * 256.0 + 0.5);
  endfunction

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d, expected %0d", req, act, exp);
    end
  endtask

  task automatic send_beat(input int s, input logic [7:0] d, input bit cf, input bit tf,
                           input logic [3:0] g);
    @(negedge clk);
    if (s == 0) begin a_valid = 1; a_word = d; a_cf = cf; a_tf = tf; a_gid = g; end
    else        begin b_valid = 1; b_word = d; b_cf = cf; b_tf = tf; b_gid = g; end
    #1;
    while (!(s == 0 ? a_ready : b_ready)) begin
      stalls[s]++;
      @(negedge clk);
      #1;
    end
    @(posedge clk);
  endtask

  // R2 framing, R3 balance on trial 0, R4 per-bit counts and entropy sum
  task automatic run_cand(input int s, input logic [3:0] g, input logic [15:0] t0,
                          input logic [15:0] t1, input logic [15:0] t2,
                          input logic [15:0] t3, input logic [15:0] t4);
    logic [15:0] tr [T];
    int nb, mn, ones, sum;
    tr[0] = t0; tr[1] = t1; tr[2] = t2; tr[3] = t3; tr[4] = t4;
    nb = (s == 0) ? 16 : 8;
    mn = (s == 0) ? 3 : 2;
    for (int t = 0; t < T; t++)
      for (int w = 0; w < nb / 8; w++)
        send_beat(s, tr[t][w*8 +: 8], t == 0 && w == 0, w == 0, g);
    ones = 0;
    for (int b = 0; b < nb; b++) ones += tr[0][b];
    sum = 0;
    for (int b = 0; b < nb; b++) begin
      int k;
      k = 0;
      for (int t = 0; t < T; t++) k += tr[t][b];
      sum += h_fix(k);
    end
    if (ones >= mn && nb - ones >= mn && (!m_have[s] || sum < m_best[s])) begin
      m_have[s] = 1; m_best[s] = sum; m_gid[s] = g;
    end
  endtask

  task automatic new_sub(input int s);
    @(negedge clk);
    if (s == 0) a_start = 1; else b_start = 1;
    @(negedge clk);
    if (s == 0) a_start = 0; else b_start = 0;
    m_have[s] = 0;
    // R10
    check("R10 valid cleared", s == 0 ? a_wv : b_wv, 0);
    check("R10 none cleared", s == 0 ? a_wn : b_wn, 0);
  endtask

  // R7 timing, R5/R6/R8 outcome
  task automatic close_check(input int s, input string req);
    @(negedge clk);
    if (s == 0) a_valid = 0; else b_valid = 0;
    repeat (3) @(negedge clk);
    if (s == 0) a_close = 1; else b_close = 1;
    @(negedge clk);
    if (s == 0) a_close = 0; else b_close = 0;
    check({req, " R7 not early"}, (s == 0) ? (a_wv | a_wn) : (b_wv | b_wn), 0);
    @(negedge clk);
    check({req, " valid"}, s == 0 ? a_wv : b_wv, int'(m_have[s]));
    check({req, " none"}, s == 0 ? a_wn : b_wn, int'(!m_have[s]));
    if (m_have[s]) check({req, " gid"}, s == 0 ? a_wg : b_wg, m_gid[s]);
  endtask

  task automatic t_reset;
    // R1
    check("R1 valid", a_wv, 0);
    check("R1 none", a_wn, 0);
    check("R1 ready", a_ready, 1);
  endtask

  task automatic t_rank;
    new_sub(0);
    stalls[0] = 0;
    run_cand(0, 4'd3, 16'h00FF, 16'h00FE, 16'h01FF, 16'h00FF, 16'h80FF);
    run_cand(0, 4'd5, 16'h0F0F, 16'h0F0F, 16'h0F0F, 16'h0F0F, 16'h0F0E);
    run_cand(0, 4'd9, 16'h3C3C, 16'h3C3C, 16'h3C3C, 16'h3C3C, 16'h3C3D);
    check("R6 tie keeps earlier (literal)", m_gid[0], 5);
    close_check(0, "R5 R6 rank");
    // R9 no stall on distinct addresses
    check("R9 no stall with two words", stalls[0], 0);
  endtask

  task automatic t_balance;
    new_sub(0);
    run_cand(0, 4'd1, 16'h0007, 16'h0007, 16'h0007, 16'h0007, 16'h000F);
    run_cand(0, 4'd2, 16'h0003, 16'h0003, 16'h0003, 16'h0003, 16'h0003);
    run_cand(0, 4'd4, 16'hFFF8, 16'hFFFF, 16'hFFFF, 16'hFFFF, 16'hFFFF);
    run_cand(0, 4'd6, 16'hFFFC, 16'hFFFC, 16'hFFFC, 16'hFFFC, 16'hFFFC);
    run_cand(0, 4'd7, 16'h00FF, 16'h0000, 16'h0000, 16'h0000, 16'h0000);
    check("R3 boundary winner (literal)", m_gid[0], 1);
    close_check(0, "R3 R4 balance");
  endtask

  task automatic t_none;
    new_sub(0);
    run_cand(0, 4'd2, 16'h0001, 16'h0001, 16'h0001, 16'h0001, 16'h0001);
    run_cand(0, 4'd3, 16'hFFFF, 16'hF0F0, 16'hF0F0, 16'hF0F0, 16'hF0F0);
    close_check(0, "R8 none eligible");
    repeat (4) @(negedge clk);
    check("R7 none held", a_wn, 1);
    new_sub(0);
    run_cand(0, 4'd11, 16'h5A5A, 16'h5A5B, 16'h7A5A, 16'h5A5A, 16'h5B5A);
    close_check(0, "R10 restart");
    repeat (4) @(negedge clk);
    check("R7 valid held", a_wv, 1);
  endtask

  task automatic t_hazard;
    new_sub(1);
    stalls[1] = 0;
    run_cand(1, 4'd1, 16'h000F, 16'h000F, 16'h000F, 16'h000F, 16'h000F);
    run_cand(1, 4'd2, 16'h000F, 16'h000E, 16'h000F, 16'h000F, 16'h000F);
    // R9 one stall per back-to-back beat on the same word
    check("R9 stall count", stalls[1], 9);
    close_check(1, "R9 R4 hazard result");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_rank();
    t_balance();
    t_none();
    t_hazard();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule